// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frame bytes from a valid/ready byte stream and scatters them across a ring of fixed-size receive buffers. Each buffer has a two-word descriptor in a small internal descriptor store. Word 0 holds the buffer address and two flags: ownership ("used") and wrap. Word 1 holds the completion status. The buffers are consecutive slices of one internal byte RAM. When a buffer is full, or when the frame ends, the writer closes it with a single descriptor update. That update records the status and hands the buffer to software by setting the used flag. After the descriptor whose wrap flag is set, the writer goes back to descriptor 0.

Software returns a buffer by clearing its used flag through a dedicated clear port. Two read ports give software access to any descriptor's words and to any byte of the buffer area. Back-pressure rules: a byte moves on a clock edge where `s_valid` and `s_ready` are both high. `s_first` and `s_last` qualify that byte. The source must hold every stream input steady while `s_valid` is high and `s_ready` is low. `s_ready` goes low only in the middle of a frame, when the next buffer is needed and its descriptor is still owned by software. At the start of a frame the writer never stalls. If no buffer is free at that point, it drops the whole frame instead.

Default configuration: 32 descriptors of 128 bytes, covering a 4096-byte area based at address 0x2000_0000.

Top module: `rx_ring_writer`

## Requirements
- R1: Byte k of a frame whose first buffer is descriptor d is stored at area offset 128*j + (k mod 128). Here j is the ring index reached after floor(k/128) ring advances from d. Descriptor i addresses area offset 128*i.
- R2: After reset, for every descriptor i: word 0 equals 0x2000_0000 + 128*i, with bit 1 (wrap) set only for the last descriptor and bit 0 (used) clear. Word 1 is zero. `ovf_flag` is 0 and `s_ready` is 1.
- R3: Mid-frame, when the byte to be written needs a descriptor whose used bit is set, `s_ready` stays low until software clears that bit. The held byte is then stored with no byte lost or repeated.
- R4: Closing a buffer is one descriptor update. Word 0 then reads with bit 0 set and its address and wrap bit unchanged. Word 1 reads bit 14 = frame start, bit 15 = frame end, bits 11:0 = length, and all other bits 0.
- R5: In a frame spanning several buffers, only the first buffer has bit 14 set and only the last has bit 15 set. Intermediate buffers have neither flag and a length field of 0. Non-final buffers also carry length 0.
- R6: The final buffer's bits 11:0 hold the total frame length in bytes, modulo 4096. A frame that fits in one buffer sets bits 14 and 15 in the same descriptor. This includes a frame of exactly 128 bytes.
- R7: The descriptor after the one with the wrap bit is descriptor 0.
- R8: If the descriptor for the first byte of a frame is still used, the whole frame is accepted with `s_ready` high and discarded. `ovf_flag` becomes 1 and stays 1 until reset. No descriptor changes, and the next frame starts at the same descriptor.
- R9: Bytes that arrive between frames without `s_first` are accepted and discarded, with no effect on descriptors or ring position.
- R10: A pulse on `sw_clr_en` clears bit 0 of word 0 of descriptor `sw_clr_idx` at the next clock edge.
- R11: Every frame starts at offset 0 of the descriptor that follows the previous frame's last buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Writer can take the byte |
| s_data | input | 8 | Stream byte |
| s_first | input | 1 | Byte is the first of a frame |
| s_last | input | 1 | Byte is the last of a frame |
| sw_clr_en | input | 1 | Return a buffer to the writer |
| sw_clr_idx | input | 5 | Descriptor to return |
| sw_rd_idx | input | 5 | Descriptor to read |
| sw_rd_addr_word | output | 32 | Word 0 of the read descriptor |
| sw_rd_stat_word | output | 32 | Word 1 of the read descriptor |
| buf_rd_addr | input | 12 | Byte offset in the buffer area |
| buf_rd_data | output | 8 | Byte at that offset |
| ovf_flag | output | 1 | Sticky: a frame was dropped for lack of a buffer |

## Verification
The hardest situations to reach are the full ring: a stall in mid-frame, and a frame dropped at its start. Both need every descriptor to be owned by software at the right moment. The bench's scoreboard monitor can withhold buffer returns. With returns withheld, a 31-buffer frame followed by a 200-byte frame fills the ring exactly, so the second frame stalls on its second buffer. Sixteen two-buffer frames return the ring position to a used descriptor, so the next frame start is dropped. Releasing the held buffers then shows that the stalled frame resumes intact and that the frame after the drop lands at the unchanged ring position.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int STAT_LEN_W     = 12;
  localparam int STAT_START_BIT = 14;
  localparam int STAT_END_BIT   = 15;
  localparam int FLAG_USED_BIT  = 0;
  localparam int FLAG_WRAP_BIT  = 1;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_FILL = 2'd1,
    FS_DROP = 2'd2
  } fill_state_e;
endpackage

// File: rtl/rxr_buf_ram.sv
module rxr_buf_ram #(
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/rxr_desc_table.sv
module rxr_desc_table
  import rxr_pkg::*;
#(
  parameter int          NUM_DESC  = 32,
  parameter int          BUF_BYTES = 128,
  parameter logic [31:0] BUF_BASE  = 32'h2000_0000,
  localparam int         IDX_W     = $clog2(NUM_DESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_en,
  input  logic [IDX_W-1:0] commit_idx,
  input  logic [31:0]      commit_stat,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_used,
  output logic             lk_wrap,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_word0,
  output logic [31:0]      rd_word1
);
  logic [NUM_DESC-1:0] used_q;
  logic [31:0]         stat_q [NUM_DESC];
  logic [31:0]         word0  [NUM_DESC];

  // Address and wrap are fixed by position; only ownership is stored.
  for (genvar g = 0; g < NUM_DESC; g++) begin : g_word0
    localparam logic [31:0] ADDR = BUF_BASE + 32'(g * BUF_BYTES);
    always_comb begin
      word0[g] = ADDR;
      word0[g][FLAG_WRAP_BIT] = (g == NUM_DESC - 1);
      word0[g][FLAG_USED_BIT] = used_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
      for (int i = 0; i < NUM_DESC; i++) stat_q[i] <= '0;
    end else begin
      if (clr_en) used_q[clr_idx] <= 1'b0;
      if (commit_en) begin
        used_q[commit_idx] <= 1'b1;
        stat_q[commit_idx] <= commit_stat;
      end
    end
  end

  assign lk_used  = word0[lk_idx][FLAG_USED_BIT];
  assign lk_wrap  = word0[lk_idx][FLAG_WRAP_BIT];
  assign rd_word0 = word0[rd_idx];
  assign rd_word1 = stat_q[rd_idx];

  assert_commit_target_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> !used_q[commit_idx]);

  assert_commit_sets_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> used_q[$past(commit_idx)]);
endmodule

// File: rtl/rxr_fill_ctrl.sv
module rxr_fill_ctrl
  import rxr_pkg::*;
#(
  parameter int  NUM_DESC  = 32,
  parameter int  BUF_BYTES = 128,
  localparam int IDX_W     = $clog2(NUM_DESC),
  localparam int OFF_W     = $clog2(BUF_BYTES),
  localparam int AREA_W    = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_first,
  input  logic              s_last,
  input  logic              cur_used,
  input  logic              cur_wrap,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              buf_we,
  output logic [AREA_W-1:0] buf_waddr,
  output logic [7:0]        buf_wdata,
  output logic              commit_en,
  output logic [31:0]       commit_stat,
  output logic              ovf
);
  localparam logic [OFF_W-1:0] OFF_MAX = OFF_W'(BUF_BYTES - 1);

  fill_state_e           state_q;
  logic [IDX_W-1:0]      idx_q, idx_next;
  logic [OFF_W-1:0]      off_q;
  logic [STAT_LEN_W-1:0] len_q, len_next;
  logic                  first_q, start_flag, fire;

  assign s_ready    = !(state_q == FS_FILL && off_q == '0 && cur_used);
  assign fire       = s_valid && s_ready;
  assign idx_next   = cur_wrap ? '0 : idx_q + 1'b1;
  assign len_next   = len_q + 1'b1;
  assign start_flag = (state_q == FS_IDLE) || first_q;

  assign buf_we    = fire && ((state_q == FS_FILL) ||
                              (state_q == FS_IDLE && s_first && !cur_used));
  assign buf_waddr = {idx_q, off_q};
  assign buf_wdata = s_data;
  assign commit_en = buf_we && (s_last || off_q == OFF_MAX);
  assign cur_idx   = idx_q;

  always_comb begin
    commit_stat = '0;
    commit_stat[STAT_START_BIT] = start_flag;
    commit_stat[STAT_END_BIT]   = s_last;
    if (s_last) commit_stat[STAT_LEN_W-1:0] = len_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      idx_q   <= '0;
      off_q   <= '0;
      len_q   <= '0;
      first_q <= 1'b0;
      ovf     <= 1'b0;
    end else if (buf_we) begin
      if (commit_en) begin
        idx_q   <= idx_next;
        off_q   <= '0;
        first_q <= 1'b0;
        len_q   <= s_last ? '0 : len_next;
        state_q <= s_last ? FS_IDLE : FS_FILL;
      end else begin
        off_q   <= off_q + 1'b1;
        len_q   <= len_next;
        first_q <= start_flag;
        state_q <= FS_FILL;
      end
    end else if (fire && state_q == FS_IDLE && s_first) begin
      ovf <= 1'b1;
      if (!s_last) state_q <= FS_DROP;
    end else if (fire && state_q == FS_DROP && s_last) begin
      state_q <= FS_IDLE;
    end
  end

  assert_stall_only_on_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |-> cur_used);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  assert_drop_keeps_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_DROP) |=> $stable(idx_q));

  assert_idle_at_offset_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_IDLE) |-> (off_q == '0 && len_q == '0));
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int          NUM_DESC  = 32,
  parameter int          BUF_BYTES = 128,
  parameter logic [31:0] BUF_BASE  = 32'h2000_0000,
  localparam int         IDX_W     = $clog2(NUM_DESC),
  localparam int         AREA_W    = IDX_W + $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_first,
  input  logic              s_last,
  input  logic              sw_clr_en,
  input  logic [IDX_W-1:0]  sw_clr_idx,
  input  logic [IDX_W-1:0]  sw_rd_idx,
  output logic [31:0]       sw_rd_addr_word,
  output logic [31:0]       sw_rd_stat_word,
  input  logic [AREA_W-1:0] buf_rd_addr,
  output logic [7:0]        buf_rd_data,
  output logic              ovf_flag
);
  logic              cur_used, cur_wrap, buf_we, commit_en;
  logic [IDX_W-1:0]  cur_idx;
  logic [AREA_W-1:0] buf_waddr;
  logic [7:0]        buf_wdata;
  logic [31:0]       commit_stat;

  rxr_fill_ctrl #(.NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES)) u_fill (
    .clk, .rst_n, .s_valid, .s_ready, .s_data, .s_first, .s_last,
    .cur_used, .cur_wrap, .cur_idx, .buf_we, .buf_waddr, .buf_wdata,
    .commit_en, .commit_stat, .ovf(ovf_flag)
  );

  rxr_desc_table #(.NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES), .BUF_BASE(BUF_BASE)) u_desc (
    .clk, .rst_n, .commit_en, .commit_idx(cur_idx), .commit_stat,
    .clr_en(sw_clr_en), .clr_idx(sw_clr_idx), .lk_idx(cur_idx),
    .lk_used(cur_used), .lk_wrap(cur_wrap), .rd_idx(sw_rd_idx),
    .rd_word0(sw_rd_addr_word), .rd_word1(sw_rd_stat_word)
  );

  rxr_buf_ram #(.DEPTH(NUM_DESC * BUF_BYTES)) u_ram (
    .clk, .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(buf_rd_addr), .rdata(buf_rd_data)
  );
endmodule

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          NUM  = 32;
  localparam int          BB   = 128;
  localparam logic [31:0] BASE = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready;
  logic        sw_clr_en = 1'b0;
  logic [4:0]  sw_clr_idx = '0, sw_rd_idx = '0;
  logic [31:0] sw_rd_addr_word, sw_rd_stat_word;
  logic [11:0] buf_rd_addr = '0;
  logic [7:0]  buf_rd_data;
  logic        ovf_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_writer #(.NUM_DESC(NUM), .BUF_BYTES(BB), .BUF_BASE(BASE)) u_rx_ring_writer (
    .clk, .rst_n, .s_valid, .s_ready, .s_data, .s_first, .s_last,
    .sw_clr_en, .sw_clr_idx, .sw_rd_idx, .sw_rd_addr_word, .sw_rd_stat_word,
    .buf_rd_addr, .buf_rd_data, .ovf_flag
  );

  typedef struct {
    int          idx;
    logic [31:0] stat;
    int          nbytes;
    string       tag;
  } item_t;

  item_t      sb_q[$];
  int         rel_q[$];
  logic [7:0] exp_mem [NUM*BB];
  int  checks = 0, errors = 0;
  int  exp_idx = 0;
  bit  free_en = 1'b1, mon_ready = 1'b0, mon_busy = 1'b0, done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_sim;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Scoreboard monitor: owns the descriptor read, buffer read and clear ports.
  function automatic bit held(input int idx);
    foreach (rel_q[i]) if (rel_q[i] == idx) return 1'b1;
    return 1'b0;
  endfunction

  task automatic release_desc(input int idx);
    @(negedge clk);
    sw_clr_idx = 5'(idx);
    sw_clr_en  = 1'b1;
    @(negedge clk);
    sw_clr_en  = 1'b0;
    sw_rd_idx  = 5'(idx);
    #1;
    check(sw_rd_addr_word[0] == 1'b0, "R10", "used bit after release", {31'b0, sw_rd_addr_word[0]}, 32'h0);
  endtask

  initial begin : monitor
    @(posedge rst_n);
    @(negedge clk);
    for (int i = 0; i < NUM; i++) begin
      sw_rd_idx = 5'(i);
      #1;
      check(sw_rd_addr_word == (BASE + 32'(BB*i) + ((i == NUM-1) ? 32'd2 : 32'd0)),
            "R2", "reset word0", sw_rd_addr_word, BASE + 32'(BB*i) + ((i == NUM-1) ? 32'd2 : 32'd0));
      check(sw_rd_stat_word == 32'h0, "R2", "reset word1", sw_rd_stat_word, 32'h0);
    end
    check(s_ready == 1'b1 && ovf_flag == 1'b0, "R2", "reset ready/ovf", {30'b0, s_ready, ovf_flag}, 32'h2);
    mon_ready = 1'b1;
    forever begin
      @(negedge clk);
      if (free_en && rel_q.size() > 0) begin
        mon_busy = 1'b1;
        release_desc(rel_q[0]);
        void'(rel_q.pop_front());
        mon_busy = 1'b0;
      end else if (sb_q.size() > 0 && !held(sb_q[0].idx)) begin
        sw_rd_idx = 5'(sb_q[0].idx);
        #1;
        if (sw_rd_addr_word[0]) begin
          item_t it;
          int    bad;
          logic [31:0] w0;
          mon_busy = 1'b1;
          it = sb_q.pop_front();
          w0 = BASE + 32'(BB*it.idx) + ((it.idx == NUM-1) ? 32'd2 : 32'd0) + 32'd1;
          check(sw_rd_addr_word == w0, (it.idx == NUM-1) ? "R7" : "R4", "word0", sw_rd_addr_word, w0);
          check(sw_rd_stat_word == it.stat, it.tag, "status word", sw_rd_stat_word, it.stat);
          bad = -1;
          for (int k = 0; k < it.nbytes; k++) begin
            buf_rd_addr = 12'(it.idx*BB + k);
            #1;
            if (bad < 0 && buf_rd_data !== exp_mem[it.idx*BB + k]) bad = k;
          end
          if (bad >= 0) begin
            buf_rd_addr = 12'(it.idx*BB + bad);
            #1;
            check(1'b0, "R1 R11", "buffer byte", {24'b0, buf_rd_data}, {24'b0, exp_mem[it.idx*BB + bad]});
          end else begin
            check(1'b1, "R1 R11", "buffer bytes", 32'h0, 32'h0);
          end
          if (free_en) release_desc(it.idx);
          else rel_q.push_back(it.idx);
          mon_busy = 1'b0;
        end
      end
    end
  end

  // Driver: drives the stream and pushes expected descriptor results.
  task automatic put_byte(input logic [7:0] b, input bit first, input bit last);
    @(negedge clk);
    s_valid = 1'b1; s_data = b; s_first = first; s_last = last;
    #1;
    while (!s_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0;
  endtask

  task automatic send_frame(input int len, input int seed, input bit drop, input string ftag);
    int off = 0;
    bit first_buf = 1'b1;
    for (int k = 0; k < len; k++) begin
      logic [7:0] b;
      bit lst;
      b   = 8'((seed + k*7 + (k >> 5)) & 8'hFF);
      lst = (k == len-1);
      if (!drop) exp_mem[exp_idx*BB + off] = b;
      put_byte(b, k == 0, lst);
      if (!drop) begin
        off++;
        if (lst || off == BB) begin
          item_t it;
          it.idx    = exp_idx;
          it.nbytes = off;
          it.stat   = '0;
          it.stat[14] = first_buf;
          it.stat[15] = lst;
          if (lst) it.stat[11:0] = 12'(len);
          it.tag = (ftag != "") ? ftag : (lst ? "R6" : (first_buf ? "R4" : "R5"));
          sb_q.push_back(it);
          exp_idx   = (exp_idx == NUM-1) ? 0 : exp_idx + 1;
          off       = 0;
          first_buf = 1'b0;
        end
      end
    end
  endtask

  task automatic wait_checked;
    do @(negedge clk); while (sb_q.size() != 0 || mon_busy);
  endtask

  task automatic wait_drain;
    do @(negedge clk); while (sb_q.size() != 0 || rel_q.size() != 0 || mon_busy);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin : main
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    wait (mon_ready);

    send_frame(40, 3, 1'b0, "R6");               // single buffer, start+end
    for (int k = 0; k < 5; k++) put_byte(8'hEE, 1'b0, 1'b0);   // R9 stray bytes
    send_frame(128, 11, 1'b0, "R9");             // exact one buffer after strays
    send_frame(300, 21, 1'b0, "");               // 3 buffers: R4, R5, R6
    send_frame(129, 33, 1'b0, "");               // 128 + 1
    send_frame(1, 45, 1'b0, "R11");
    wait_drain();

    // R3: fill ring with returns withheld, second frame must stall.
    free_en = 1'b0;
    send_frame(31*BB, 50, 1'b0, "");
    fork
      send_frame(200, 60, 1'b0, "");
      begin
        bit seen = 1'b0;
        int n = 0, low = 0;
        while (!seen && n < 8000) begin
          @(negedge clk);
          #1;
          if (s_valid && !s_ready) seen = 1'b1;
          n++;
        end
        check(seen, "R3", "stall on owned descriptor", {31'b0, seen}, 32'h1);
        repeat (30) begin
          @(negedge clk);
          #1;
          if (!s_ready) low++;
        end
        check(low == 30, "R3", "ready held low while owned", 32'(low), 32'd30);
        free_en = 1'b1;
      end
    join
    wait_drain();

    // R8: ring full at a frame start -> drop.
    free_en = 1'b0;
    for (int f = 0; f < 16; f++) send_frame(200, 70 + f, 1'b0, "");
    wait_checked();
    check(ovf_flag == 1'b0, "R8", "ovf before drop", {31'b0, ovf_flag}, 32'h0);
    send_frame(50, 99, 1'b1, "");
    repeat (2) @(negedge clk);
    check(ovf_flag == 1'b1, "R8", "ovf after drop", {31'b0, ovf_flag}, 32'h1);
    check(sb_q.size() == 0, "R8", "no descriptor from dropped frame", 32'(sb_q.size()), 32'h0);
    free_en = 1'b1;
    wait_drain();
    send_frame(60, 111, 1'b0, "R8");             // lands at unchanged position
    send_frame(10, 123, 1'b0, "R11");
    wait_drain();
    check(ovf_flag == 1'b1, "R8", "ovf sticky", {31'b0, ovf_flag}, 32'h1);

    repeat (5) @(negedge clk);
    finish_sim();
  end
endmodule